// File: doc/BRIEF.md
# Dual-Commit Reorder Buffer

A circular buffer that tracks in-flight instructions in program order for an out-of-order core. The rename stage writes up to two new entries per cycle at the tail. Each entry carries a PC, an instruction type, an architectural destination, a new physical destination and the physical register it displaced. Two writeback ports mark entries complete by index and may attach an exception with a cause code, or a branch mispredict flag.

Retirement takes up to two complete entries per cycle from the head, strictly in order. A clean entry produces a commit notification. Rename uses this notification to update its committed map and to free the displaced physical register. An entry that carries an exception does not commit. It raises a pipeline flush with its cause and PC. A mispredicted branch commits and then discards every younger entry, which truncates the tail back to the slot after the branch. Either flush empties the buffer. Rename restores its speculative state and releases the speculative registers from the committed map. Fetch is redirected outside this block.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: alloc_rdy_o is 1, alloc_idx_o gives indices 0 and 1, and commit_vld_o, exc_flush_o and mis_flush_o are 0.
- R2: Allocation is in order at the tail. Lane 0 takes index alloc_idx_o[0] and lane 1 takes alloc_idx_o[1], which is alloc_idx_o[0]+1 modulo DEPTH. Lane 1 is accepted only together with lane 0.
- R3: alloc_rdy_o is 1 exactly when at least two slots are free. A request while alloc_rdy_o is 0 is ignored and leaves the tail index unchanged.
- R4: An entry is marked complete by a writeback port addressing its index. An entry that is not complete never retires.
- R5: Up to two entries retire per cycle from the head. Lane 1 retires only if lane 0 retires in the same cycle. A committing lane presents that entry's PC, type, architectural destination, physical destination and old physical register.
- R6: A complete entry at a retiring position that carries an exception is not committed (its commit_vld_o bit is 0). exc_flush_o pulses in that cycle with the entry's cause and PC, any older entry in lane 0 still commits, and the buffer is empty in the next cycle.
- R7: A complete mispredicted branch at a retiring position commits, and mis_flush_o pulses with its PC in the same cycle. Younger entries are discarded, allocation requests in that cycle are ignored, and the next allocation index is the slot after the branch.
- R8: An entry flagged with both an exception and a mispredict is treated as an exception: exc_flush_o is 1 and mis_flush_o is 0.
- R9: Head and tail wrap around DEPTH entries. A full buffer (DEPTH live entries) and an empty one are told apart, and a full buffer drains completely in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_vld_i | input | 2 | Allocation request per lane |
| alloc_pc_i | input | 2 x PC_W | PC per lane |
| alloc_type_i | input | 2 x TYPE_W | Instruction type per lane |
| alloc_adst_i | input | 2 x AREG_W | Architectural destination per lane |
| alloc_pdst_i | input | 2 x PREG_W | New physical destination per lane |
| alloc_pold_i | input | 2 x PREG_W | Displaced physical register per lane |
| alloc_rdy_o | output | 1 | At least two free slots |
| alloc_idx_o | output | 2 x IDX_W | Index given to each allocation lane |
| wb_vld_i | input | 2 | Writeback valid per port |
| wb_idx_i | input | 2 x IDX_W | Entry index completed per port |
| wb_exc_i | input | 2 | Completion carries an exception |
| wb_cause_i | input | 2 x CAUSE_W | Exception cause per port |
| wb_mis_i | input | 2 | Completion is a mispredicted branch |
| commit_vld_o | output | 2 | Commit per retire lane |
| commit_pc_o | output | 2 x PC_W | PC of committing entry |
| commit_type_o | output | 2 x TYPE_W | Type of committing entry |
| commit_adst_o | output | 2 x AREG_W | Architectural destination to update |
| commit_pdst_o | output | 2 x PREG_W | Physical register now architectural |
| commit_pold_o | output | 2 x PREG_W | Physical register to free |
| exc_flush_o | output | 1 | Exception flush pulse |
| exc_cause_o | output | CAUSE_W | Cause of the exception |
| exc_pc_o | output | PC_W | PC of the faulting entry |
| mis_flush_o | output | 1 | Mispredict flush pulse |
| mis_pc_o | output | PC_W | PC of the mispredicted branch |

## Verification
Corrupt pointer state shows in the same cycle on alloc_idx_o and alloc_rdy_o, because both come straight from the head and tail registers. A lost or misplaced completion flag shows one cycle after the writeback as a missing, extra or out-of-order commit_vld_o bit, or as commit fields that belong to the wrong entry. A flush that leaves stale valid bits shows as a commit of a discarded instruction or as a wrong next allocation index on the cycle after the flush pulse. The sweeps below drive every done pattern of the head pair, a full wrap and each flush position for these effects.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

  typedef struct packed {
    logic valid;
    logic done;
    logic exc;
    logic mis;
  } slot_st_t;

  typedef enum logic [1:0] {
    RET_NONE,
    RET_OK,
    RET_EXC,
    RET_MIS
  } ret_kind_e;

  function automatic ret_kind_e classify(slot_st_t s);
    if (!s.valid || !s.done) return RET_NONE;
    if (s.exc) return RET_EXC;
    if (s.mis) return RET_MIS;
    return RET_OK;
  endfunction

endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
module rob_ptrs #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       alloc_n_i,
  input  logic [1:0]       retire_n_i,
  input  logic             flush_i,
  output logic [IDX_W:0]   head_o,
  output logic [IDX_W:0]   tail_o,
  output logic [IDX_W:0]   occ_o,
  output logic             rdy_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W:0] head_q, tail_q, head_n;

  // extra top bit separates full from empty
  assign occ_o  = tail_q - head_q;
  assign rdy_o  = {1'b0, occ_o} <= (IDX_W+2)'(DEPTH - 2);
  assign head_n = head_q + (IDX_W+1)'(retire_n_i);
  assign head_o = head_q;
  assign tail_o = tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= flush_i ? head_n : tail_q + (IDX_W+1)'(alloc_n_i);
    end
  end
endmodule

// File: rtl/rob_retire_sel.sv
`timescale 1ns/1ps
module rob_retire_sel (
  input  rob_pkg::slot_st_t [1:0] st_i,
  output logic [1:0]              commit_o,
  output logic [1:0]              retire_n_o,
  output logic                    exc_o,
  output logic                    mis_o,
  output logic                    fslot_o
);
  import rob_pkg::*;

  ret_kind_e k0, k1;
  assign k0 = classify(st_i[0]);
  assign k1 = classify(st_i[1]);

  always_comb begin
    commit_o   = 2'b00;
    retire_n_o = 2'd0;
    exc_o      = 1'b0;
    mis_o      = 1'b0;
    fslot_o    = 1'b0;
    unique case (k0)
      RET_EXC: begin
        retire_n_o = 2'd1;
        exc_o      = 1'b1;
      end
      RET_MIS: begin
        commit_o   = 2'b01;
        retire_n_o = 2'd1;
        mis_o      = 1'b1;
      end
      RET_OK: begin
        commit_o   = 2'b01;
        retire_n_o = 2'd1;
        unique case (k1)
          RET_EXC: begin
            retire_n_o = 2'd2;
            exc_o      = 1'b1;
            fslot_o    = 1'b1;
          end
          RET_MIS: begin
            commit_o   = 2'b11;
            retire_n_o = 2'd2;
            mis_o      = 1'b1;
            fslot_o    = 1'b1;
          end
          RET_OK: begin
            commit_o   = 2'b11;
            retire_n_o = 2'd2;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/reorder_buffer.sv
`timescale 1ns/1ps
module reorder_buffer #(
  parameter int DEPTH   = 64,
  parameter int PC_W    = 64,
  parameter int PREG_W  = 6,
  parameter int AREG_W  = 5,
  parameter int TYPE_W  = 4,
  parameter int CAUSE_W = 6,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  alloc_vld_i,
  input  logic [1:0][PC_W-1:0]        alloc_pc_i,
  input  logic [1:0][TYPE_W-1:0]      alloc_type_i,
  input  logic [1:0][AREG_W-1:0]      alloc_adst_i,
  input  logic [1:0][PREG_W-1:0]      alloc_pdst_i,
  input  logic [1:0][PREG_W-1:0]      alloc_pold_i,
  output logic                        alloc_rdy_o,
  output logic [1:0][IDX_W-1:0]       alloc_idx_o,
  input  logic [1:0]                  wb_vld_i,
  input  logic [1:0][IDX_W-1:0]       wb_idx_i,
  input  logic [1:0]                  wb_exc_i,
  input  logic [1:0][CAUSE_W-1:0]     wb_cause_i,
  input  logic [1:0]                  wb_mis_i,
  output logic [1:0]                  commit_vld_o,
  output logic [1:0][PC_W-1:0]        commit_pc_o,
  output logic [1:0][TYPE_W-1:0]      commit_type_o,
  output logic [1:0][AREG_W-1:0]      commit_adst_o,
  output logic [1:0][PREG_W-1:0]      commit_pdst_o,
  output logic [1:0][PREG_W-1:0]      commit_pold_o,
  output logic                        exc_flush_o,
  output logic [CAUSE_W-1:0]          exc_cause_o,
  output logic [PC_W-1:0]             exc_pc_o,
  output logic                        mis_flush_o,
  output logic [PC_W-1:0]             mis_pc_o
);
  import rob_pkg::*;

  logic [PC_W-1:0]    pc_q    [DEPTH];
  logic [TYPE_W-1:0]  type_q  [DEPTH];
  logic [AREG_W-1:0]  adst_q  [DEPTH];
  logic [PREG_W-1:0]  pdst_q  [DEPTH];
  logic [PREG_W-1:0]  pold_q  [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];

  logic [DEPTH-1:0] valid_w, done_w, exc_w, mis_w;

  logic [IDX_W:0]   head, tail, occ;
  logic             rdy, flush, exc, mis, fslot;
  logic [1:0]       alloc_n, retire_n, commit;
  logic [IDX_W-1:0] a0, a1, h0, h1, hf;
  logic [1:0][IDX_W-1:0] hsel;
  slot_st_t [1:0]   st;

  assign a0 = tail[IDX_W-1:0];
  assign a1 = a0 + 1'b1;
  assign h0 = head[IDX_W-1:0];
  assign h1 = h0 + 1'b1;
  assign hsel[0] = h0;
  assign hsel[1] = h1;
  assign hf = fslot ? h1 : h0;
  assign flush = exc | mis;

  // lane 1 rides only with lane 0; nothing enters during a flush
  assign alloc_n = (alloc_vld_i[0] && rdy && !flush) ?
                   (alloc_vld_i[1] ? 2'd2 : 2'd1) : 2'd0;

  rob_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_n_i  (alloc_n),
    .retire_n_i (retire_n),
    .flush_i    (flush),
    .head_o     (head),
    .tail_o     (tail),
    .occ_o      (occ),
    .rdy_o      (rdy)
  );

  for (genvar k = 0; k < 2; k++) begin : g_slot
    assign st[k] = '{valid: valid_w[hsel[k]], done: done_w[hsel[k]],
                     exc: exc_w[hsel[k]], mis: mis_w[hsel[k]]};
    assign commit_pc_o[k]   = pc_q[hsel[k]];
    assign commit_type_o[k] = type_q[hsel[k]];
    assign commit_adst_o[k] = adst_q[hsel[k]];
    assign commit_pdst_o[k] = pdst_q[hsel[k]];
    assign commit_pold_o[k] = pold_q[hsel[k]];
  end

  rob_retire_sel u_sel (
    .st_i       (st),
    .commit_o   (commit),
    .retire_n_o (retire_n),
    .exc_o      (exc),
    .mis_o      (mis),
    .fslot_o    (fslot)
  );

  always_ff @(posedge clk_i) begin
    if (alloc_n != 2'd0) begin
      pc_q[a0]   <= alloc_pc_i[0];
      type_q[a0] <= alloc_type_i[0];
      adst_q[a0] <= alloc_adst_i[0];
      pdst_q[a0] <= alloc_pdst_i[0];
      pold_q[a0] <= alloc_pold_i[0];
    end
    if (alloc_n == 2'd2) begin
      pc_q[a1]   <= alloc_pc_i[1];
      type_q[a1] <= alloc_type_i[1];
      adst_q[a1] <= alloc_adst_i[1];
      pdst_q[a1] <= alloc_pdst_i[1];
      pold_q[a1] <= alloc_pold_i[1];
    end
    for (int k = 0; k < 2; k++)
      if (wb_vld_i[k] && wb_exc_i[k]) cause_q[wb_idx_i[k]] <= wb_cause_i[k];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic v_q, d_q, e_q, m_q;
    logic wr, ret, hit0, hit1;
    assign wr   = (alloc_n != 2'd0 && a0 == IDX_W'(i)) ||
                  (alloc_n == 2'd2 && a1 == IDX_W'(i));
    assign ret  = (retire_n != 2'd0 && h0 == IDX_W'(i)) ||
                  (retire_n == 2'd2 && h1 == IDX_W'(i));
    assign hit0 = wb_vld_i[0] && wb_idx_i[0] == IDX_W'(i);
    assign hit1 = wb_vld_i[1] && wb_idx_i[1] == IDX_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        e_q <= 1'b0;
        m_q <= 1'b0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else if (wr) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
        e_q <= 1'b0;
        m_q <= 1'b0;
      end else begin
        if (ret) v_q <= 1'b0;
        if (v_q && (hit0 || hit1)) begin
          d_q <= 1'b1;
          e_q <= e_q | (hit0 & wb_exc_i[0]) | (hit1 & wb_exc_i[1]);
          m_q <= m_q | (hit0 & wb_mis_i[0]) | (hit1 & wb_mis_i[1]);
        end
      end
    end

    assign valid_w[i] = v_q;
    assign done_w[i]  = d_q;
    assign exc_w[i]   = e_q;
    assign mis_w[i]   = m_q;
  end

  assign alloc_rdy_o    = rdy;
  assign alloc_idx_o[0] = a0;
  assign alloc_idx_o[1] = a1;
  assign commit_vld_o   = commit;
  assign exc_flush_o    = exc;
  assign exc_cause_o    = cause_q[hf];
  assign exc_pc_o       = pc_q[hf];
  assign mis_flush_o    = mis;
  assign mis_pc_o       = pc_q[hf];
endmodule

// File: rtl/rob_checker.sv
`timescale 1ns/1ps
module rob_checker #(
  parameter int IDX_W = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  alloc_rdy_i,
  input logic [1:0][IDX_W-1:0] alloc_idx_i,
  input logic [1:0]            commit_vld_i,
  input logic                  exc_flush_i,
  input logic                  mis_flush_i,
  input logic [IDX_W:0]        occ_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  assert_commit_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_vld_i[1] |-> commit_vld_i[0]);

  assert_flush_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_flush_i && mis_flush_i));

  assert_exc_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_flush_i |=> (occ_i == '0));

  assert_mis_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_flush_i |=> (occ_i == '0));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, occ_i} <= (IDX_W+2)'(DEPTH));

  assert_stall_holds_tail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_rdy_i && !exc_flush_i && !mis_flush_i) |=> $stable(alloc_idx_i));

  assert_full_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, occ_i} == (IDX_W+2)'(DEPTH)) |-> !alloc_rdy_i);
endmodule

bind reorder_buffer rob_checker #(.IDX_W(IDX_W)) u_rob_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .alloc_rdy_i  (alloc_rdy_o),
  .alloc_idx_i  (alloc_idx_o),
  .commit_vld_i (commit_vld_o),
  .exc_flush_i  (exc_flush_o),
  .mis_flush_i  (mis_flush_o),
  .occ_i        (occ)
);

// File: tb/test_reorder_buffer.sv
`timescale 1ns/1ps
module test_reorder_buffer;
  localparam int DEPTH = 8, PC_W = 32, PREG_W = 6, AREG_W = 5, TYPE_W = 4, CAUSE_W = 6;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]               alloc_vld;
  logic [1:0][PC_W-1:0]     alloc_pc;
  logic [1:0][TYPE_W-1:0]   alloc_type;
  logic [1:0][AREG_W-1:0]   alloc_adst;
  logic [1:0][PREG_W-1:0]   alloc_pdst, alloc_pold;
  logic                     alloc_rdy;
  logic [1:0][IDX_W-1:0]    alloc_idx;
  logic [1:0]               wb_vld, wb_exc, wb_mis;
  logic [1:0][IDX_W-1:0]    wb_idx;
  logic [1:0][CAUSE_W-1:0]  wb_cause;
  logic [1:0]               commit_vld;
  logic [1:0][PC_W-1:0]     commit_pc;
  logic [1:0][TYPE_W-1:0]   commit_type;
  logic [1:0][AREG_W-1:0]   commit_adst;
  logic [1:0][PREG_W-1:0]   commit_pdst, commit_pold;
  logic                     exc_flush, mis_flush;
  logic [CAUSE_W-1:0]       exc_cause;
  logic [PC_W-1:0]          exc_pc, mis_pc;

  reorder_buffer #(.DEPTH(DEPTH), .PC_W(PC_W), .PREG_W(PREG_W), .AREG_W(AREG_W),
                   .TYPE_W(TYPE_W), .CAUSE_W(CAUSE_W)) i_reorder_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_vld_i(alloc_vld), .alloc_pc_i(alloc_pc), .alloc_type_i(alloc_type),
    .alloc_adst_i(alloc_adst), .alloc_pdst_i(alloc_pdst), .alloc_pold_i(alloc_pold),
    .alloc_rdy_o(alloc_rdy), .alloc_idx_o(alloc_idx),
    .wb_vld_i(wb_vld), .wb_idx_i(wb_idx), .wb_exc_i(wb_exc), .wb_cause_i(wb_cause),
    .wb_mis_i(wb_mis),
    .commit_vld_o(commit_vld), .commit_pc_o(commit_pc), .commit_type_o(commit_type),
    .commit_adst_o(commit_adst), .commit_pdst_o(commit_pdst), .commit_pold_o(commit_pold),
    .exc_flush_o(exc_flush), .exc_cause_o(exc_cause), .exc_pc_o(exc_pc),
    .mis_flush_o(mis_flush), .mis_pc_o(mis_pc)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int hp = 0, tp = 0, nseq = 0;
  int seq_at [DEPTH];

  function automatic logic [PC_W-1:0]   pc_of(int s);   return PC_W'(32'h1000 + 4 * s); endfunction
  function automatic logic [PREG_W-1:0] pdst_of(int s); return PREG_W'(s * 5 + 3);      endfunction
  function automatic logic [PREG_W-1:0] pold_of(int s); return PREG_W'(s * 7 + 1);      endfunction
  function automatic logic [AREG_W-1:0] adst_of(int s); return AREG_W'(s + 1);          endfunction
  function automatic logic [TYPE_W-1:0] type_of(int s); return TYPE_W'(s);              endfunction

  task automatic eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    alloc_vld = '0; alloc_pc = '0; alloc_type = '0; alloc_adst = '0;
    alloc_pdst = '0; alloc_pold = '0;
    wb_vld = '0; wb_idx = '0; wb_exc = '0; wb_cause = '0; wb_mis = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic drive_alloc(input int n, input int s0);
    for (int k = 0; k < n; k++) begin
      alloc_vld[k]  = 1'b1;
      alloc_pc[k]   = pc_of(s0 + k);
      alloc_type[k] = type_of(s0 + k);
      alloc_adst[k] = adst_of(s0 + k);
      alloc_pdst[k] = pdst_of(s0 + k);
      alloc_pold[k] = pold_of(s0 + k);
    end
  endtask

  // accepted allocation: check indices, record in model
  task automatic put_alloc(input int n);
    eq("R2", "alloc_idx0", alloc_idx[0], tp % DEPTH);
    eq("R2", "alloc_idx1", alloc_idx[1], (tp + 1) % DEPTH);
    drive_alloc(n, nseq);
    for (int k = 0; k < n; k++) seq_at[(tp + k) % DEPTH] = nseq + k;
    tp += n;
    nseq += n;
  endtask

  task automatic put_wb(input int k, input int ptr, input bit e, input int cause, input bit m);
    wb_vld[k]   = 1'b1;
    wb_idx[k]   = IDX_W'(ptr % DEPTH);
    wb_exc[k]   = e;
    wb_cause[k] = CAUSE_W'(cause);
    wb_mis[k]   = m;
  endtask

  task automatic exp_commit(input string req, input logic [1:0] v, input int p0);
    eq(req, "commit_vld", commit_vld, v);
    for (int k = 0; k < 2; k++) begin
      if (v[k]) begin
        int s;
        s = seq_at[(p0 + k) % DEPTH];
        eq(req, "commit_pc",   commit_pc[k],   pc_of(s));
        eq(req, "commit_type", commit_type[k], type_of(s));
        eq(req, "commit_adst", commit_adst[k], adst_of(s));
        eq(req, "commit_pdst", commit_pdst[k], pdst_of(s));
        eq(req, "commit_pold", commit_pold[k], pold_of(s));
      end
    end
  endtask

  task automatic exp_empty(input string req);
    eq(req, "alloc_rdy", alloc_rdy, 1);
    eq(req, "commit_vld", commit_vld, 0);
    eq(req, "alloc_idx0", alloc_idx[0], tp % DEPTH);
    eq(req, "exc_flush", exc_flush, 0);
    eq(req, "mis_flush", mis_flush, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    exp_empty("R1");
    eq("R1", "alloc_idx1", alloc_idx[1], 1);

    // R2/R4/R5 in-order completion
    put_alloc(2);
    tick();
    eq("R4", "commit_vld_not_done", commit_vld, 0);
    put_wb(1, hp + 1, 0, 0, 0);
    tick();
    eq("R5", "commit_vld_younger_only", commit_vld, 0);
    put_wb(0, hp, 0, 0, 0);
    tick();
    exp_commit("R5", 2'b11, hp);
    tick();
    hp += 2;
    exp_empty("R5");

    // R5 sweep over done patterns of the head pair
    for (int pat = 0; pat < 4; pat++) begin
      put_alloc(2);
      tick();
      if (pat[0]) put_wb(0, hp, 0, 0, 0);
      if (pat[1]) put_wb(1, hp + 1, 0, 0, 0);
      tick();
      exp_commit("R5", (pat == 3) ? 2'b11 : (pat == 1) ? 2'b01 : 2'b00, hp);
      if (pat == 1) begin
        hp += 1;
        put_wb(1, hp, 0, 0, 0);
        tick();
        exp_commit("R5", 2'b01, hp);
        tick();
        hp += 1;
      end else if (pat == 3) begin
        tick();
        hp += 2;
      end else begin
        if (!pat[0]) put_wb(0, hp, 0, 0, 0);
        if (!pat[1]) put_wb(1, hp + 1, 0, 0, 0);
        tick();
        exp_commit("R4", 2'b11, hp);
        tick();
        hp += 2;
      end
      exp_empty("R5");
    end

    // R3/R9 fill to full across the wrap, stall, drain
    for (int j = 0; j < DEPTH / 2; j++) begin
      eq("R3", "alloc_rdy_fill", alloc_rdy, 1);
      put_alloc(2);
      tick();
    end
    eq("R3", "alloc_rdy_full", alloc_rdy, 0);
    eq("R9", "alloc_idx_full", alloc_idx[0], hp % DEPTH);
    eq("R9", "commit_vld_full", commit_vld, 0);
    drive_alloc(2, 1000);
    tick();
    eq("R3", "alloc_idx_stall", alloc_idx[0], tp % DEPTH);
    eq("R3", "alloc_rdy_stall", alloc_rdy, 0);
    for (int j = 0; j < DEPTH / 2; j++) begin
      put_wb(0, hp + 2 * j, 0, 0, 0);
      put_wb(1, hp + 2 * j + 1, 0, 0, 0);
      tick();
      exp_commit("R9", 2'b11, hp + 2 * j);
    end
    tick();
    hp += DEPTH;
    exp_empty("R9");

    // R6 exception in lane 1, lane 0 commits, younger discarded
    begin
      int a;
      a = hp;
      put_alloc(2); tick();
      put_alloc(2); tick();
      put_wb(0, a, 0, 0, 0);
      put_wb(1, a + 1, 1, 5, 0);
      tick();
      exp_commit("R6", 2'b01, a);
      eq("R6", "exc_flush", exc_flush, 1);
      eq("R6", "exc_cause", exc_cause, 5);
      eq("R6", "exc_pc", exc_pc, pc_of(seq_at[(a + 1) % DEPTH]));
      eq("R6", "mis_flush", mis_flush, 0);
      put_wb(0, a + 2, 0, 0, 0);
      tick();
      hp = a + 2;
      tp = a + 2;
      exp_empty("R6");
      put_alloc(2); tick();
      put_wb(0, hp, 0, 0, 0);
      put_wb(1, hp + 1, 0, 0, 0);
      tick();
      exp_commit("R6", 2'b11, hp);
      tick();
      hp += 2;
      exp_empty("R6");
    end

    // R8 exception plus mispredict on lane 0
    begin
      int a;
      a = hp;
      put_alloc(2); tick();
      put_wb(0, a, 1, 9, 1);
      put_wb(1, a + 1, 0, 0, 0);
      tick();
      exp_commit("R8", 2'b00, a);
      eq("R8", "exc_flush", exc_flush, 1);
      eq("R8", "mis_flush", mis_flush, 0);
      eq("R8", "exc_cause", exc_cause, 9);
      eq("R8", "exc_pc", exc_pc, pc_of(seq_at[a % DEPTH]));
      tick();
      hp = a + 1;
      tp = a + 1;
      exp_empty("R8");
    end

    // R7 mispredict in lane 1, allocation during flush ignored
    begin
      int a;
      a = hp;
      put_alloc(2); tick();
      put_alloc(2); tick();
      put_wb(0, a, 0, 0, 0);
      put_wb(1, a + 1, 0, 0, 1);
      tick();
      exp_commit("R7", 2'b11, a);
      eq("R7", "mis_flush", mis_flush, 1);
      eq("R7", "exc_flush", exc_flush, 0);
      eq("R7", "mis_pc", mis_pc, pc_of(seq_at[(a + 1) % DEPTH]));
      drive_alloc(2, 2000);
      tick();
      hp = a + 2;
      tp = a + 2;
      exp_empty("R7");
    end

    // R7 mispredict in lane 0 stops lane 1
    begin
      int a;
      a = hp;
      put_alloc(2); tick();
      put_wb(0, a, 0, 0, 1);
      put_wb(1, a + 1, 0, 0, 0);
      tick();
      exp_commit("R7", 2'b01, a);
      eq("R7", "mis_flush_lane0", mis_flush, 1);
      eq("R7", "mis_pc_lane0", mis_pc, pc_of(seq_at[a % DEPTH]));
      tick();
      hp = a + 1;
      tp = a + 1;
      exp_empty("R7");
    end

    repeat (2) @(negedge clk);
    summary();
  end
endmodule